// File: doc/BRIEF.md
# Single-Bit Boolean Processor

This unit carries out one single-bit operation per accepted request. It works on a carry flag, which acts as a one-bit accumulator, and on one addressable bit taken from a 256-bit space. The unit can clear, set or complement either the carry or a bit. It can AND or OR a bit, or the inverse of that bit, into the carry. It can copy a bit into the carry or copy the carry into a bit. It also evaluates the conditions of the bit-test jumps and reports the outcome as a branch-taken flag.

The 256-bit space is held inside the block so that results can be observed. Bits 00h–7Fh belong to a 16-byte RAM window. Bits 80h–FFh belong to registers whose byte addresses are multiples of eight. One of these registers is a port. Its bits normally read the external pins, but read-modify-write operations read the output latch instead. Three bits of the status register are protected against writes.

A request is presented with `op_valid` high for one cycle. Its results appear on the registered outputs after the next rising clock edge, with `res_valid` high for that one cycle. The stored bit space and the carry are also updated at that edge. Consecutive cycles may each carry a request.

Top module: `bit_logic_unit`

## Requirements
- R1: After a synchronous active-low reset, the carry, `res_valid`, `branch_taken`, `bit_we` and `bit_wdata` are 0. Every stored bit is 0 except the eight port bits (bit addresses 90h–97h), which reset to 1, so `port_latch` reads FFh.
- R2: Op code 1 clears the carry, code 2 sets it, and code 3 complements it. The new carry shows on `carry` one cycle after the request.
- R3: Op codes 4, 5 and 6 clear, set and complement the addressed bit. Each raises `bit_we` with the new value on `bit_wdata`, and the stored bit takes that value.
- R4: Op code 7 ANDs the carry with the bit, code 8 ANDs it with the inverted bit, code 9 ORs it with the bit, and code 10 ORs it with the inverted bit. The result goes to the carry.
- R5: Op code 11 copies the addressed bit into the carry. Op code 12 writes the carry into the addressed bit.
- R6: `branch_taken` goes high for op code 13 when the carry is 1, for code 14 when the carry is 0, for code 15 when the bit is 1, and for code 16 when the bit is 0. None of these four codes writes anything.
- R7: Op code 17 (test-and-clear) raises `branch_taken` when the bit is 1 and in the same operation writes 0 to that bit. When the bit is 0 it writes nothing.
- R8: Bits 0, 2 and 6 of the status register at byte D0h (bit addresses D0h, D2h and D6h) are protected. Writes aimed at them are dropped, `bit_we` stays 0, and the stored value does not change.
- R9: Codes 1–3 never raise `bit_we`. Codes 4, 5, 6, 12 and 17 never change the carry.
- R10: Every result reports the operand's byte address and bit position. For addresses below 80h the byte address is 20h plus address bits 6:3. For addresses of 80h and above it is the address with bits 2:0 cleared. In both cases the bit position is address bits 2:0.
- R11: A port bit read by codes 6 or 17 returns the output latch. A port bit read by any other code returns `port_pin`. `port_latch` always shows the stored port byte.
- R12: When `op_valid` is low, nothing changes and `res_valid` stays 0. Op code 0 and codes 18–31 are no-ops: they give a result with carry unchanged and `branch_taken` and `bit_we` both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Request strobe, one operation per cycle |
| op_code | input | 5 | Operation selector (see requirements) |
| bit_addr | input | 8 | Operand bit address |
| port_pin | input | 8 | External pin levels of the port register |
| res_valid | output | 1 | Result outputs valid for this cycle |
| carry | output | 1 | Current carry flag |
| branch_taken | output | 1 | Jump condition outcome |
| bit_we | output | 1 | Bit write performed |
| bit_wdata | output | 1 | Value written (0 when no write) |
| wr_byte_addr | output | 8 | Byte address of the operand bit |
| wr_bit_pos | output | 3 | Bit position of the operand within its byte |
| port_latch | output | 8 | Stored port output latch |

## Verification
The assertions take for granted that `op_code` and `bit_addr` are stable and fully known whenever `op_valid` is high, and that `port_pin` is never unknown. The stimulus drives every input only on the falling edge and drives `port_pin` as a defined byte from reset onward. The scoreboard model decides whether a port read uses the latch or the pins purely from the op code, as the requirements state, so the stimulus changes the pins between requests to make the two sources differ. The stimulus also aims test-and-clear and complement at protected and port addresses, where more than one rule applies at once.

// File: rtl/blu_pkg.sv
// Shared types for the single-bit Boolean processor.
// Assumes a 5-bit op code; codes outside the enum behave as no-ops.
package blu_pkg;

    typedef enum logic [4:0] {
        OP_NOP    = 5'd0,
        OP_CLR_C  = 5'd1,
        OP_SET_C  = 5'd2,
        OP_CPL_C  = 5'd3,
        OP_CLR_B  = 5'd4,
        OP_SET_B  = 5'd5,
        OP_CPL_B  = 5'd6,
        OP_ANL_B  = 5'd7,
        OP_ANL_NB = 5'd8,
        OP_ORL_B  = 5'd9,
        OP_ORL_NB = 5'd10,
        OP_MOV_CB = 5'd11,
        OP_MOV_BC = 5'd12,
        OP_JC     = 5'd13,
        OP_JNC    = 5'd14,
        OP_JB     = 5'd15,
        OP_JNB    = 5'd16,
        OP_JBC    = 5'd17
    } blu_op_e;

    typedef struct packed {
        logic carry_nxt;
        logic wr_en;
        logic wr_val;
        logic taken;
    } blu_result_t;

    // Read-modify-write codes read a port's latch, not its pins.
    function automatic logic reads_latch(input logic [4:0] op);
        return (op == OP_CPL_B) || (op == OP_JBC);
    endfunction

endpackage

// File: rtl/bit_addr_decode.sv
// Maps a bit address to its byte address and bit position, and flags
// port and protected-status locations. Purely combinational.
// Assumes SFR-style byte addresses are multiples of eight.
module bit_addr_decode #(
    parameter int AW          = 8,
    parameter int RAM_BASE    = 8'h20,
    parameter int PORT_BYTE   = 8'h90,
    parameter int STATUS_BYTE = 8'hD0,
    parameter int PROT_MASK   = 8'b0100_0101
) (
    input  logic [AW-1:0] addr,
    output logic [AW-1:0] byte_addr,
    output logic [2:0]    bit_pos,
    output logic          is_port,
    output logic          is_protected
);
    localparam logic [AW-1:0] RAM_B  = AW'(RAM_BASE);
    localparam logic [AW-1:0] PORT_B = AW'(PORT_BYTE);
    localparam logic [AW-1:0] STAT_B = AW'(STATUS_BYTE);
    localparam logic [7:0]    PMASK  = 8'(PROT_MASK);

    logic low_region;

    // Region split on the top address bit; byte address per region.
    always_comb begin
        low_region = ~addr[AW-1];
        bit_pos    = addr[2:0];
        if (low_region)
            byte_addr = RAM_B + AW'(addr[AW-2:3]);
        else
            byte_addr = {addr[AW-1:3], 3'b000};
        is_port      = ~low_region && (byte_addr == PORT_B);
        is_protected = ~low_region && (byte_addr == STAT_B) && PMASK[bit_pos];
    end

endmodule

// File: rtl/bit_eval.sv
// Combinational evaluator: given op, carry and the source bit value it
// returns the next carry, the bit write request and the jump outcome.
// Assumes the caller applies protection and the valid strobe.
module bit_eval
    import blu_pkg::*;
(
    input  logic [4:0]  op,
    input  logic        carry_in,
    input  logic        src_bit,
    output blu_result_t res
);
    // Decode the operation into carry, write and branch results.
    always_comb begin
        res.carry_nxt = carry_in;
        res.wr_en     = 1'b0;
        res.wr_val    = 1'b0;
        res.taken     = 1'b0;
        case (op)
            OP_CLR_C:  res.carry_nxt = 1'b0;
            OP_SET_C:  res.carry_nxt = 1'b1;
            OP_CPL_C:  res.carry_nxt = ~carry_in;
            OP_CLR_B:  begin res.wr_en = 1'b1; res.wr_val = 1'b0;     end
            OP_SET_B:  begin res.wr_en = 1'b1; res.wr_val = 1'b1;     end
            OP_CPL_B:  begin res.wr_en = 1'b1; res.wr_val = ~src_bit; end
            OP_ANL_B:  res.carry_nxt = carry_in & src_bit;
            OP_ANL_NB: res.carry_nxt = carry_in & ~src_bit;
            OP_ORL_B:  res.carry_nxt = carry_in | src_bit;
            OP_ORL_NB: res.carry_nxt = carry_in | ~src_bit;
            OP_MOV_CB: res.carry_nxt = src_bit;
            OP_MOV_BC: begin res.wr_en = 1'b1; res.wr_val = carry_in; end
            OP_JC:     res.taken = carry_in;
            OP_JNC:    res.taken = ~carry_in;
            OP_JB:     res.taken = src_bit;
            OP_JNB:    res.taken = ~src_bit;
            OP_JBC:    begin res.taken = src_bit; res.wr_en = src_bit; end
            default:   ;
        endcase
    end

endmodule

// File: rtl/bit_storage.sv
// Bit-addressed storage of N_BITS flops, one per bit address. Port bits
// reset to 1, all others to 0. Reads of port bits return the pins unless
// use_latch is set. Assumes SFR bit address equals byte address plus
// bit position.
module bit_storage #(
    parameter int N_BITS    = 256,
    parameter int PORT_BYTE = 8'h90,
    localparam int AW       = $clog2(N_BITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          use_latch,
    input  logic [7:0]    port_pin,
    input  logic          wr_en,
    input  logic          wr_val,
    output logic          rd_bit,
    output logic [7:0]    port_latch
);
    localparam logic [AW-1:0] PORT_A = AW'(PORT_BYTE);

    logic [N_BITS-1:0] bits;

    for (genvar i = 0; i < N_BITS; i++) begin : g_bit
        localparam logic RST_VAL = (i >= PORT_BYTE) && (i < PORT_BYTE + 8);
        logic q;
        // One stored bit: reset value, then written when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= RST_VAL;
            else if (wr_en && (addr == AW'(i)))
                q <= wr_val;
        end
        assign bits[i] = q;
    end

    logic addr_is_port;

    // Read path with pin/latch selection for the port byte.
    always_comb begin
        addr_is_port = (addr[AW-1:3] == PORT_A[AW-1:3]);
        if (addr_is_port && !use_latch)
            rd_bit = port_pin[addr[2:0]];
        else
            rd_bit = bits[addr];
    end

    assign port_latch = bits[PORT_BYTE +: 8];

    // A write must land on the addressed flop in the next cycle.
    p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (bits[$past(addr)] == $past(wr_val)));

endmodule

// File: rtl/bit_logic_unit.sv
// Top of the single-bit Boolean processor. Accepts one op per cycle on
// op_valid, updates carry and bit storage at the next edge, and presents
// registered results for one cycle on res_valid.
// Assumes op_code and bit_addr are known whenever op_valid is high.
module bit_logic_unit
    import blu_pkg::*;
#(
    parameter int N_BITS      = 256,
    parameter int RAM_BASE    = 8'h20,
    parameter int PORT_BYTE   = 8'h90,
    parameter int STATUS_BYTE = 8'hD0,
    parameter int PROT_MASK   = 8'b0100_0101
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       op_valid,
    input  logic [4:0] op_code,
    input  logic [7:0] bit_addr,
    input  logic [7:0] port_pin,
    output logic       res_valid,
    output logic       carry,
    output logic       branch_taken,
    output logic       bit_we,
    output logic       bit_wdata,
    output logic [7:0] wr_byte_addr,
    output logic [2:0] wr_bit_pos,
    output logic [7:0] port_latch
);
    localparam int AW = $clog2(N_BITS);

    logic [AW-1:0] dec_byte;
    logic [2:0]    dec_pos;
    logic          dec_port;
    logic          dec_prot;
    logic          src_bit;
    logic          carry_q;
    logic          eff_we;
    blu_result_t   res;

    bit_addr_decode #(
        .AW(AW), .RAM_BASE(RAM_BASE), .PORT_BYTE(PORT_BYTE),
        .STATUS_BYTE(STATUS_BYTE), .PROT_MASK(PROT_MASK)
    ) u_dec (
        .addr(bit_addr), .byte_addr(dec_byte), .bit_pos(dec_pos),
        .is_port(dec_port), .is_protected(dec_prot)
    );

    bit_eval u_eval (
        .op(op_code), .carry_in(carry_q), .src_bit(src_bit), .res(res)
    );

    // Gate the write by the strobe and the status-bit protection.
    always_comb eff_we = op_valid && res.wr_en && !dec_prot;

    bit_storage #(.N_BITS(N_BITS), .PORT_BYTE(PORT_BYTE)) u_store (
        .clk(clk), .rst_n(rst_n), .addr(bit_addr),
        .use_latch(reads_latch(op_code)), .port_pin(port_pin),
        .wr_en(eff_we), .wr_val(res.wr_val),
        .rd_bit(src_bit), .port_latch(port_latch)
    );

    // Carry register and registered result outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            carry_q      <= 1'b0;
            res_valid    <= 1'b0;
            branch_taken <= 1'b0;
            bit_we       <= 1'b0;
            bit_wdata    <= 1'b0;
            wr_byte_addr <= '0;
            wr_bit_pos   <= '0;
        end else begin
            res_valid <= op_valid;
            if (op_valid) begin
                carry_q      <= res.carry_nxt;
                branch_taken <= res.taken;
                bit_we       <= eff_we;
                bit_wdata    <= eff_we & res.wr_val;
                wr_byte_addr <= dec_byte;
                wr_bit_pos   <= dec_pos;
            end else begin
                branch_taken <= 1'b0;
                bit_we       <= 1'b0;
                bit_wdata    <= 1'b0;
            end
        end
    end

    assign carry = carry_q;

    // Protected status bits never see a write.
    p_status_protect_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && dec_prot) |=> !bit_we);

    // Carry-only ops never write a bit.
    p_carry_ops_no_we_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == OP_CLR_C || op_code == OP_SET_C ||
                      op_code == OP_CPL_C)) |=> !bit_we);

    // Bit-targeted ops leave carry alone.
    p_bit_ops_keep_carry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == OP_CLR_B || op_code == OP_SET_B ||
                      op_code == OP_CPL_B || op_code == OP_MOV_BC ||
                      op_code == OP_JBC)) |=> $stable(carry_q));

    // Test-and-clear on a set, unprotected bit jumps and clears it.
    p_jbc_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_JBC && src_bit && !dec_prot)
        |=> (branch_taken && bit_we && !bit_wdata));

    // No result without a request.
    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!res_valid && !bit_we && $stable(carry_q)));

endmodule

// File: tb/tb_bit_logic_unit.sv
// Scoreboard bench: the driver predicts each result from a bench model
// and queues it; the monitor compares results as they appear.
module tb_bit_logic_unit;
    import blu_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [4:0] op_code = '0;
    logic [7:0] bit_addr = '0;
    logic [7:0] port_pin = 8'h0F;
    logic       res_valid, carry, branch_taken, bit_we, bit_wdata;
    logic [7:0] wr_byte_addr, port_latch;
    logic [2:0] wr_bit_pos;

    always #5 clk = ~clk;

    bit_logic_unit dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .bit_addr(bit_addr), .port_pin(port_pin), .res_valid(res_valid),
        .carry(carry), .branch_taken(branch_taken), .bit_we(bit_we),
        .bit_wdata(bit_wdata), .wr_byte_addr(wr_byte_addr),
        .wr_bit_pos(wr_bit_pos), .port_latch(port_latch)
    );

    typedef struct {
        logic [15:0] v;   // {carry, taken, we, wdata, byte, pos, 1'b0}
        string       tag;
    } exp_t;

    exp_t       sb_q[$];
    int         n_checks = 0;
    int         n_fail = 0;
    logic [255:0] m_bits;
    logic       m_carry;

    task automatic check(input logic [15:0] act, input logic [15:0] exp,
                         input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic m_read(input logic [7:0] a, input logic [4:0] op);
        if (a[7:3] == 5'h12 && !(op == 5'd6 || op == 5'd17))
            return port_pin[a[2:0]];
        return m_bits[a];
    endfunction

    // Driver: predict, queue, apply for one cycle (called after a negedge).
    task automatic do_op(input logic [4:0] op, input logic [7:0] a,
                         input string tag);
        logic b, c, t, w, wv, prot;
        logic [7:0] by;
        exp_t e;
        b = m_read(a, op);
        c = m_carry; t = 1'b0; w = 1'b0; wv = 1'b0;
        by = a[7] ? {a[7:3], 3'b000} : (8'h20 + {4'd0, a[6:3]});
        prot = (by == 8'hD0) && (a[2:0] == 3'd0 || a[2:0] == 3'd2 ||
                                 a[2:0] == 3'd6);
        case (op)
            5'd1:  c = 1'b0;
            5'd2:  c = 1'b1;
            5'd3:  c = ~m_carry;
            5'd4:  begin w = 1'b1; wv = 1'b0; end
            5'd5:  begin w = 1'b1; wv = 1'b1; end
            5'd6:  begin w = 1'b1; wv = ~b; end
            5'd7:  c = m_carry & b;
            5'd8:  c = m_carry & ~b;
            5'd9:  c = m_carry | b;
            5'd10: c = m_carry | ~b;
            5'd11: c = b;
            5'd12: begin w = 1'b1; wv = m_carry; end
            5'd13: t = m_carry;
            5'd14: t = ~m_carry;
            5'd15: t = b;
            5'd16: t = ~b;
            5'd17: begin t = b; w = b; wv = 1'b0; end
            default: ;
        endcase
        if (prot) w = 1'b0;
        if (!w) wv = 1'b0;
        if (w) m_bits[a] = wv;
        m_carry = c;
        e.v = {c, t, w, wv, by, a[2:0], 1'b0};
        e.tag = tag;
        sb_q.push_back(e);
        op_code = op; bit_addr = a; op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    // Monitor: compare each produced result against the queue head.
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (sb_q.size() == 0) begin
                n_checks++; n_fail++;
                $display("FAIL R12: actual unexpected result expected none");
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check({carry, branch_taken, bit_we, bit_wdata, wr_byte_addr,
                       wr_bit_pos, 1'b0}, e.v, e.tag);
            end
        end
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures",
                     n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        m_bits = '0; m_bits[8'h90 +: 8] = 8'hFF; m_carry = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check({8'd0, res_valid, carry, branch_taken, bit_we, bit_wdata, 3'd0},
              16'd0, "R1 outputs");
        check({8'd0, port_latch}, 16'h00FF, "R1 port latch");
        // R2 carry ops
        do_op(5'd2, 8'h00, "R2 set");
        do_op(5'd3, 8'h00, "R2 cpl");
        do_op(5'd3, 8'h00, "R2 cpl back");
        do_op(5'd1, 8'h00, "R2/R9 clr");
        // R3 bit ops, readback by JB; R10 mapping in RAM
        do_op(5'd5, 8'h0B, "R3/R10 set ram bit");
        do_op(5'd15, 8'h0B, "R3 readback set");
        do_op(5'd6, 8'h0B, "R3 cpl");
        do_op(5'd16, 8'h0B, "R3/R6 readback cpl");
        do_op(5'd5, 8'h7F, "R10 top ram bit");
        do_op(5'd4, 8'h7F, "R3 clr");
        do_op(5'd5, 8'hE3, "R10 sfr bit");
        // R4 logic into carry
        do_op(5'd2, 8'h00, "R2 set");
        do_op(5'd7, 8'hE3, "R4 anl b");
        do_op(5'd8, 8'hE3, "R4 anl nb");
        do_op(5'd9, 8'hE3, "R4 orl b");
        do_op(5'd1, 8'h00, "R2 clr");
        do_op(5'd10, 8'h7F, "R4 orl nb");
        // R5 moves, R9 carry kept by bit ops
        do_op(5'd12, 8'h21, "R5/R9 mov bit<-c");
        do_op(5'd1, 8'h00, "R2 clr");
        do_op(5'd11, 8'h21, "R5 mov c<-bit");
        do_op(5'd4, 8'h21, "R9 bit op keeps carry");
        // R6 jumps
        do_op(5'd13, 8'h00, "R6 jc");
        do_op(5'd14, 8'h00, "R6 jnc");
        do_op(5'd15, 8'h21, "R6 jb");
        do_op(5'd16, 8'h21, "R6 jnb");
        // R7 test-and-clear
        do_op(5'd17, 8'hE3, "R7 jbc set");
        do_op(5'd17, 8'hE3, "R7 jbc clear");
        // R8 protected status bits
        do_op(5'd5, 8'hD2, "R8 set ov");
        do_op(5'd15, 8'hD2, "R8 ov unchanged");
        do_op(5'd12, 8'hD0, "R8 mov to parity");
        do_op(5'd5, 8'hD1, "R8 unprotected neighbour");
        do_op(5'd17, 8'hD1, "R8/R7 jbc neighbour");
        do_op(5'd6, 8'hD6, "R8 cpl aux");
        // R11 port pin vs latch (pins 0Fh, latch FFh)
        do_op(5'd15, 8'h94, "R11 jb reads pin");
        do_op(5'd17, 8'h94, "R11 jbc reads latch");
        check({8'd0, port_latch}, 16'h00EF, "R11 latch after jbc");
        do_op(5'd6, 8'h95, "R11 cpl reads latch");
        check({8'd0, port_latch}, 16'h00CF, "R11 latch after cpl");
        port_pin = 8'hF0;
        do_op(5'd11, 8'h91, "R11 mov reads pin");
        do_op(5'd11, 8'h97, "R11 mov reads pin hi");
        // R12 idle and unused codes
        op_code = 5'd3; bit_addr = 8'h00;
        repeat (3) @(negedge clk);
        do_op(5'd13, 8'h00, "R12 idle kept carry");
        do_op(5'd20, 8'h33, "R12 unused code");
        do_op(5'd0, 8'h0B, "R12 nop");
        repeat (3) @(negedge clk);
        check({15'd0, 1'(sb_q.size() != 0)}, 16'd0, "R12 queue drained");
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_checks, n_fail);
        $finish;
    end

endmodule